// File: doc/BRIEF.md
# HMAC-SHA-256 Keyed Tag Engine With Cached Key States

This block computes HMAC-SHA-256 tags for messages that arrive as already padded 512-bit blocks. It owns a SHA-256 compression core (one round per clock) and a sequencer around it. For a run, the sequencer masks the supplied key to its byte length and XORs it with the inner pad. That block is hashed first. The resulting chaining value then seeds the message blocks, in order, up to the block flagged last. The outer pass follows: the key XOR outer pad is hashed, then a single padded block that carries the inner digest. The final value is the tag.

The chaining values produced by the two key blocks are kept in registers after every full run. When a later run asks for them, the engine starts the message directly from the cached inner state and finishes from the cached outer state. It then skips both key compressions, so the same key can authenticate any number of messages without hashing the key again. Message blocks enter through a valid/ready port. The source must hold `msg_valid`, `msg_data` and `msg_last` stable while `msg_ready` is low. A block transfers on any rising edge where both `msg_valid` and `msg_ready` are high. `msg_ready` falls after each transfer and rises again only once that block has been folded into the chaining value. The source pads the message itself, and its length field must count the 512 key bits in front of the message.

Top module: `hmac_sha256_inner`

## Requirements
- R1: Key byte j sits at bits [511-8j -: 8]. Bytes with j >= `key_len` are treated as zero, and a `key_len` of 64 or more keeps all 64 bytes. Masking is applied to the `key` value sampled with `start`.
- R2: A full run first compresses, from the standard SHA-256 initial value, the masked key XOR a block of 64 bytes of 0x36.
- R3: Message blocks are chained in acceptance order, each starting from the previous block's result. The block accepted with `msg_last` high ends the inner hash.
- R4: The outer pass compresses the masked key XOR 64 bytes of 0x5c. It then compresses {inner digest, 0x80, 184 zero bits, 64-bit length 768}. The result is presented on `tag`, with SHA-256 word 0 in bits [255:224].
- R5: With `reuse_key` high at `start`, and once a full run has completed, no key block is hashed. The run uses the cached states of the last full run. It gives that key's tag at least 128 cycles earlier than a full run, and `key` and `key_len` are ignored.
- R6: With `reuse_key` high while no full run has completed since reset, a full run is performed.
- R7: `msg_ready` is high only while the engine waits for a message block. It is low in the cycle after a transfer and stays low until that block is chained, including the cycle in which the core finishes. No block is taken after the last one.
- R8: `tag_valid` is a one-cycle pulse per run, and `tag` changes only in that cycle and then holds.
- R9: `start` is ignored while a run is in progress.
- R10: After reset, `msg_ready` and `tag_valid` are low and `tag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (accepted when idle) |
| reuse_key | input | 1 | Use cached key states for this run |
| key | input | 512 | Key bytes, byte 0 in the top byte |
| key_len | input | 7 | Key length in bytes (0 to 64) |
| msg_valid | input | 1 | Message block offered |
| msg_ready | output | 1 | Engine takes the offered block |
| msg_data | input | 512 | Padded message block |
| msg_last | input | 1 | Offered block is the final one |
| tag | output | 256 | HMAC-SHA-256 tag |
| tag_valid | output | 1 | One-cycle pulse when `tag` is new |

## Verification
The collision that matters is a message block still being offered at the moment the core finishes the previous one. In that cycle the engine must fold the finished result into the chaining value and must not accept the waiting block against the stale state. The bench provokes this by presenting the next block with no gap right after each transfer, so the offer spans the core's finishing cycle. It judges the result by comparing every tag with a bench model of HMAC, and by checking that `msg_ready` is low after each transfer. A stray `start` pulse is also injected mid-run alongside message traffic, and a wrong tag would expose it.

// File: rtl/hmac_pkg.sv
`timescale 1ns/1ps
package hmac_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 512;
  localparam int DIG_W  = 256;
  localparam int NWORDS = DIG_W / WORD_W;
  localparam int KBYTES = BLK_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INNER_KEY, ST_INNER_MSG, ST_OUTER_KEY, ST_OUTER_DIG, ST_DONE
  } hmac_state_e;

  localparam logic [DIG_W-1:0] SHA_IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [0:63][WORD_W-1:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t k_word(input logic [5:0] idx);
    return K_TAB[idx];
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // Single block that closes the outer hash: digest, pad marker, length 768.
  function automatic logic [BLK_W-1:0] outer_block(input logic [DIG_W-1:0] d);
    return {d, 8'h80, 184'd0, 64'd768};
  endfunction
endpackage

// File: rtl/hmac_wsched.sv
`timescale 1ns/1ps
module hmac_wsched
  import hmac_pkg::*;
#(
  parameter int WIN = 16
) (
  input  logic             clk,
  input  logic             load,
  input  logic             adv,
  input  logic [BLK_W-1:0] block,
  output word_t            w_cur
);
  localparam int TAP_A = WIN - 2;
  localparam int TAP_B = WIN - 7;

  word_t win_q [WIN];
  word_t w_next;

  assign w_next = sml_s1(win_q[TAP_A]) + win_q[TAP_B] + sml_s0(win_q[1]) + win_q[0];
  assign w_cur  = win_q[0];

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_win
      always_ff @(posedge clk) begin
        if (load) begin
          win_q[i] <= block[BLK_W-1-WORD_W*i -: WORD_W];
        end else if (adv) begin
          if (i == WIN - 1) win_q[i] <= w_next;
          else              win_q[i] <= win_q[(i + 1) % WIN];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hmac_compress.sv
`timescale 1ns/1ps
module hmac_compress
  import hmac_pkg::*;
#(
  parameter int ROUNDS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIG_W-1:0] init_st,
  input  logic [BLK_W-1:0] block,
  output logic             busy,
  output logic             done,
  output logic [DIG_W-1:0] digest
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  logic [CW-1:0]    rnd_q;
  logic             busy_q, done_q;
  logic [DIG_W-1:0] chain_q;
  word_t            work_q [NWORDS];
  word_t            w_t, t1, t2;

  hmac_wsched #(.WIN(16)) i_sched (
    .clk   (clk),
    .load  (go),
    .adv   (busy_q),
    .block (block),
    .w_cur (w_t)
  );

  always_comb begin
    t1 = work_q[7] + big_s1(work_q[4])
       + ((work_q[4] & work_q[5]) ^ (~work_q[4] & work_q[6]))
       + k_word(6'(rnd_q)) + w_t;
    t2 = big_s0(work_q[0])
       + ((work_q[0] & work_q[1]) ^ (work_q[0] & work_q[2]) ^ (work_q[1] & work_q[2]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        rnd_q  <= '0;
      end else if (busy_q) begin
        if (rnd_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go) chain_q <= init_st;
  end

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_work
      always_ff @(posedge clk) begin
        if (go) begin
          work_q[i] <= init_st[DIG_W-1-WORD_W*i -: WORD_W];
        end else if (busy_q) begin
          if (i == 0)      work_q[i] <= t1 + t2;
          else if (i == 4) work_q[i] <= work_q[3] + t1;
          else             work_q[i] <= work_q[(i + NWORDS - 1) % NWORDS];
        end
      end
      assign digest[DIG_W-1-WORD_W*i -: WORD_W] =
        chain_q[DIG_W-1-WORD_W*i -: WORD_W] + work_q[i];
    end
  endgenerate

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/hmac_keyprep.sv
`timescale 1ns/1ps
module hmac_keyprep
  import hmac_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [BLK_W-1:0] key_raw,
  input  logic [LEN_W-1:0] key_len,
  output logic [BLK_W-1:0] key_ipad,
  output logic [BLK_W-1:0] key_opad
);
  localparam logic [7:0] IPAD_BYTE = 8'h36;
  localparam logic [7:0] OPAD_BYTE = 8'h5c;

  generate
    for (genvar j = 0; j < KBYTES; j++) begin : g_byte
      logic [7:0] kb;
      assign kb = (key_len > LEN_W'(j)) ? key_raw[BLK_W-1-8*j -: 8] : 8'h00;
      assign key_ipad[BLK_W-1-8*j -: 8] = kb ^ IPAD_BYTE;
      assign key_opad[BLK_W-1-8*j -: 8] = kb ^ OPAD_BYTE;
    end
  endgenerate
endmodule

// File: rtl/hmac_sha256_inner.sv
`timescale 1ns/1ps
module hmac_sha256_inner
  import hmac_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reuse_key,
  input  logic [BLK_W-1:0] key,
  input  logic [LEN_W-1:0] key_len,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [BLK_W-1:0] msg_data,
  input  logic             msg_last,
  output logic [DIG_W-1:0] tag,
  output logic             tag_valid
);
  hmac_state_e      st_q, st_d;
  logic             have_q, last_q, use_q;
  logic [DIG_W-1:0] chain_q, ipad_st_q, opad_st_q, tag_q;
  logic [BLK_W-1:0] opad_blk_q;

  logic             core_go, core_busy, core_done;
  logic [DIG_W-1:0] core_init, core_digest;
  logic [BLK_W-1:0] core_blk, key_ipad, key_opad;
  logic             take_blk;

  hmac_keyprep #(.LEN_W(LEN_W)) i_keyprep (
    .key_raw  (key),
    .key_len  (key_len),
    .key_ipad (key_ipad),
    .key_opad (key_opad)
  );

  hmac_compress #(.ROUNDS(64)) i_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (core_go),
    .init_st (core_init),
    .block   (core_blk),
    .busy    (core_busy),
    .done    (core_done),
    .digest  (core_digest)
  );

  always_comb begin
    st_d      = st_q;
    core_go   = 1'b0;
    core_init = SHA_IV;
    core_blk  = key_ipad;
    msg_ready = 1'b0;
    take_blk  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (reuse_key && have_q) begin
            st_d = ST_INNER_MSG;
          end else begin
            core_go = 1'b1;
            st_d    = ST_INNER_KEY;
          end
        end
      end
      ST_INNER_KEY: begin
        if (core_done) st_d = ST_INNER_MSG;
      end
      ST_INNER_MSG: begin
        msg_ready = !core_busy && !core_done && !last_q;
        if (core_done && last_q) begin
          core_go = 1'b1;
          if (use_q) begin
            core_init = opad_st_q;
            core_blk  = outer_block(core_digest);
            st_d      = ST_OUTER_DIG;
          end else begin
            core_init = SHA_IV;
            core_blk  = opad_blk_q;
            st_d      = ST_OUTER_KEY;
          end
        end else if (msg_valid && msg_ready) begin
          take_blk  = 1'b1;
          core_go   = 1'b1;
          core_init = chain_q;
          core_blk  = msg_data;
        end
      end
      ST_OUTER_KEY: begin
        if (core_done) begin
          core_go   = 1'b1;
          core_init = core_digest;
          core_blk  = outer_block(chain_q);
          st_d      = ST_OUTER_DIG;
        end
      end
      ST_OUTER_DIG: begin
        if (core_done) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      have_q <= 1'b0;
      last_q <= 1'b0;
      use_q  <= 1'b0;
      tag_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        use_q  <= reuse_key && have_q;
        last_q <= 1'b0;
      end
      if (take_blk && msg_last) last_q <= 1'b1;
      if (st_q == ST_OUTER_KEY && core_done) have_q <= 1'b1;
      if (st_q == ST_OUTER_DIG && core_done) tag_q  <= core_digest;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE && start) begin
      opad_blk_q <= key_opad;
      if (reuse_key && have_q) chain_q <= ipad_st_q;
    end
    if (st_q == ST_INNER_KEY && core_done) begin
      ipad_st_q <= core_digest;
      chain_q   <= core_digest;
    end
    if (st_q == ST_INNER_MSG && core_done) chain_q <= core_digest;
    if (st_q == ST_OUTER_KEY && core_done) opad_st_q <= core_digest;
  end

  assign tag       = tag_q;
  assign tag_valid = (st_q == ST_DONE);
endmodule

// File: rtl/hmac_sha256_inner_chk.sv
`timescale 1ns/1ps
module hmac_sha256_inner_chk
  import hmac_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic             tag_valid,
  input logic [DIG_W-1:0] tag,
  input hmac_state_e      st,
  input logic             core_busy,
  input logic             core_done
);
  p_tag_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> !tag_valid);

  p_tag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag) |-> tag_valid);

  p_ready_core_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> (!core_busy && !core_done));

  p_accept_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_ready);

  p_done_after_rounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> $past(core_busy));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != ST_IDLE && st != ST_DONE) |=> (st != ST_IDLE));
endmodule

bind hmac_sha256_inner hmac_sha256_inner_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .tag_valid (tag_valid),
  .tag       (tag),
  .st        (st_q),
  .core_busy (core_busy),
  .core_done (core_done)
);

// File: tb/test_hmac_sha256_inner.sv
`timescale 1ns/1ps
module test_hmac_sha256_inner;
  import hmac_pkg::k_word;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, reuse_key = 1'b0;
  logic [511:0] key = '0;
  logic [6:0]   key_len = '0;
  logic         msg_valid = 1'b0, msg_last = 1'b0;
  logic [511:0] msg_data = '0;
  logic         msg_ready, tag_valid;
  logic [255:0] tag;

  int n_checks = 0;
  int n_err = 0;
  logic [511:0] mblk [4];
  logic [511:0] ref_key = '0;
  bit           ref_have = 1'b0;

  localparam logic [255:0] IV0 = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                  32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  always #2.5 clk = ~clk;

  hmac_sha256_inner i_hmac_sha256_inner (
    .clk(clk), .rst_n(rst_n), .start(start), .reuse_key(reuse_key), .key(key),
    .key_len(key_len), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .msg_last(msg_last), .tag(tag), .tag_valid(tag_valid));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_blk(input logic [255:0] st, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = st[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6]))
         + k_word(6'(t)) + w[t];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = st[255-32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [511:0] mask_key(input logic [511:0] k, input int len);
    logic [511:0] m = k;
    for (int j = 0; j < 64; j++) if (j >= len) m[511-8*j -: 8] = 8'h00;
    return m;
  endfunction

  function automatic logic [255:0] ref_hmac(input logic [511:0] km, input int n);
    logic [255:0] s, o;
    s = ref_blk(IV0, km ^ {64{8'h36}});
    for (int i = 0; i < n; i++) s = ref_blk(s, mblk[i]);
    o = ref_blk(IV0, km ^ {64{8'h5c}});
    return ref_blk(o, {s, 8'h80, 184'd0, 64'd768});
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // One run; counts cycles from the start edge to the tag pulse.
  task automatic run_hmac(input logic [511:0] k, input int klen, input bit reuse,
                          input int n, input int gapmax, input bit poke,
                          output logic [255:0] tag_o, output int lat);
    logic [255:0] held;
    @(negedge clk);
    start = 1'b1; key = k; key_len = 7'(klen); reuse_key = reuse; lat = 0;
    @(negedge clk);
    start = 1'b0; key = rnd512(); key_len = 7'($urandom % 65); lat++;
    for (int b = 0; b < n; b++) begin
      msg_valid = 1'b1; msg_data = mblk[b]; msg_last = (b == n - 1);
      while (!msg_ready) begin @(negedge clk); lat++; end
      @(negedge clk); lat++;
      check(!msg_ready, "R7", "ready after transfer", 256'(msg_ready), 256'd0);
      if (b != n - 1) begin
        // Gap 0: next block is already offered while the core finishes.
        msg_data = mblk[b+1];
        if (gapmax > 0) begin
          msg_valid = 1'b0;
          for (int g = 0; g < int'($urandom % (gapmax + 1)); g++) begin
            msg_data = rnd512(); @(negedge clk); lat++;
          end
        end
      end else begin
        msg_valid = 1'b0; msg_data = rnd512(); msg_last = 1'b0;
      end
      if (poke && b == 0) begin
        start = 1'b1; key = rnd512(); reuse_key = ~reuse;
        @(negedge clk); lat++;
        start = 1'b0;
      end
    end
    msg_valid = 1'b0;
    while (!tag_valid) begin @(negedge clk); lat++; end
    tag_o = tag; held = tag;
    @(negedge clk);
    check(!tag_valid, "R8", "pulse width", 256'(tag_valid), 256'd0);
    check(tag == held, "R8", "tag hold", tag, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected tag");
    finish_run();
  end

  initial begin
    logic [255:0] got, exp;
    logic [511:0] k;
    int lat_full, lat_reuse, lat, len, n;
    bit rs;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    check(!msg_ready, "R10", "reset ready", 256'(msg_ready), 256'd0);
    check(!tag_valid, "R10", "reset tag_valid", 256'(tag_valid), 256'd0);
    check(tag == '0, "R10", "reset tag", tag, 256'd0);
    rst_n = 1'b1;

    // R6 reuse with nothing cached; R1 junk beyond key_len; R2/R4 known tag
    mblk[0] = {64'h4869205468657265, 8'h80, 376'd0, 64'd576};
    k = {{20{8'h0b}}, 352'd0};
    k[351:0] = rnd512()[351:0];
    run_hmac(k, 20, 1'b1, 1, 0, 1'b0, got, lat);
    exp = 256'hb0344c61d8db38535ca8afceaf0bf12b881dc200c9833da726e9376c2e32cff7;
    check(got == exp, "R6", "reuse without cache, vector 1", got, exp);
    check(got == ref_hmac(mask_key(k, 20), 1), "R1", "masked key model", got, ref_hmac(mask_key(k, 20), 1));

    // R4 vector 2, full run
    mblk[0] = {224'h7768617420646f2079612077616e7420666f72206e6f7468696e673f, 8'h80, 216'd0, 64'd736};
    k = {32'h4a656665, 480'd0};
    run_hmac(k, 4, 1'b0, 1, 0, 1'b0, got, lat_full);
    exp = 256'h5bdcc146bf60754e6a042426089575c75a003f089d2739839dec58b964ec3843;
    check(got == exp, "R4", "full run, vector 2", got, exp);
    ref_key = mask_key(k, 4); ref_have = 1'b1;

    // R5 cached states, key input junk
    run_hmac(rnd512(), 1, 1'b1, 1, 0, 1'b0, got, lat_reuse);
    check(got == exp, "R5", "cached run tag", got, exp);
    check(lat_reuse + 128 <= lat_full, "R5", "cached run latency",
          256'(lat_reuse), 256'(lat_full - 128));

    // Random runs, lengths 0 and 64 first; R3 multi-block chaining; R9 stray start
    for (int it = 0; it < 10; it++) begin
      len = (it == 0) ? 0 : (it == 1) ? 64 : int'($urandom % 65);
      n   = 1 + int'($urandom % 4);
      rs  = (it > 2) && ($urandom % 2 == 1);
      k   = rnd512();
      for (int b = 0; b < 4; b++) mblk[b] = rnd512();
      run_hmac(k, len, rs, n, (it % 3 == 0) ? 0 : 3, (it % 4 == 2), got, lat);
      if (rs && ref_have) exp = ref_hmac(ref_key, n);
      else begin
        exp = ref_hmac(mask_key(k, len), n);
        ref_key = mask_key(k, len); ref_have = 1'b1;
      end
      if (it % 4 == 2) check(got == exp, "R9", "stray start mid-run", got, exp);
      else if (rs)     check(got == exp, "R5", "random cached run", got, exp);
      else if (n > 1)  check(got == exp, "R3", "random multi-block", got, exp);
      else             check(got == exp, "R1", "random key length", got, exp);
    end
    finish_run();
  end
endmodule